// File: doc/BRIEF.md
# Configuration Quadword Stream Router

This block sits behind a write-only keyhole window in a device-configuration path. Software or a DMA engine writes 32-bit words into the window. Address bits [3:2] of each write pick one of four slots in a quadword. A write to the last slot completes the quadword. The block then decodes the first word as a header and emits a packet to one of fifteen row targets, or to all of them at once. Each packet carries a target register address and four 32-bit data lanes, qualified by a one-cycle strobe per row.

Large blocks of frame data are sent without a header per quadword. A control packet that addresses the bulk-data register loads a quadword countdown and remembers the row it named. While that countdown is nonzero, every completed quadword goes to the remembered row as raw bulk data, whatever its first word holds. When the decompress control input is high, completed quadwords are thrown away. Two sticky error flags report programming mistakes. A separate clear strobe resets them.

Top module: `cfg_qword_router`

## Requirements
- R1: A write stores its data in the slot given by wr_addr[3:2]; the other address bits have no effect. Only a write to slot 3 completes a quadword, and the resulting packet appears on the outputs in the clock cycle after the completing write.
- R2: Completing a quadword clears slots 0 to 2 of the gather buffer. A slot that is not rewritten before the next completion therefore contributes zero.
- R3: While the bulk countdown is nonzero, each completed quadword is emitted to the latched row with register address 0x02. Word k of the quadword is placed on pkt_data[32k+31:32k]. The countdown then drops by one.
- R4: With the countdown at zero, a header with packet type 0x02 in bits [31:24] and register address 0x02 in bits [13:8] loads word 1 into the countdown and latches the row in bits [20:16]. It produces no packet.
- R5: With the countdown at zero, a header with packet type 0x01 is emitted with register address bits [13:8]. Words 1, 2 and 3 go on pkt_data[31:0], [63:32] and [95:64], and pkt_data[127:96] is zero.
- R6: Row code 31 drives all fifteen row_valid bits. A row code below 15 drives only row_valid[row].
- R7: A packet routed to a row code from 15 to 30 drives no row_valid bit and sets err_bad_row, which stays set until cleared.
- R8: A countdown load whose value is not a multiple of 25 sets err_bulk_len. A high err_clr clears both flags, but a flag being set in the same cycle stays set.
- R9: When decomp_en is high at the completing write, the quadword is dropped: no packet is emitted and the countdown is unchanged.
- R10: With the countdown at zero, any other header is ignored. This covers other packet types, and type 0x02 with a register address other than 0x02. Such a header neither emits a packet nor loads the countdown.
- R11: Synchronous reset clears row_valid, both error flags, the countdown, the latched row and the gather buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Keyhole write strobe |
| wr_addr | input | ADDR_W | Keyhole write byte address; bits [3:2] select the slot |
| wr_data | input | 32 | Keyhole write data |
| decomp_en | input | 1 | Decompress mode; completed quadwords are dropped while high |
| err_clr | input | 1 | Clears both sticky error flags |
| row_valid | output | NUM_ROWS | One-cycle packet strobe per row target |
| pkt_reg | output | 6 | Register address of the current packet |
| pkt_data | output | 128 | Four data lanes of the current packet, lane k at [32k+31:32k] |
| err_bulk_len | output | 1 | Sticky: countdown loaded with a value that is not a multiple of 25 |
| err_bad_row | output | 1 | Sticky: packet routed to a nonexistent row |

## Verification
The assertions assume that decomp_en and err_clr are steady across each clock edge. They also assume reset is held for at least two cycles, so that every $past term refers to a cleared state. The stimulus changes every input only on the falling edge and holds reset for several cycles. The bench reproduces the gather, the countdown and the routing with its own behavioural model and compares every output on every cycle. Directed sequences cover the corner cases. These include a completion whose earlier slots were not rewritten, a countdown that ends exactly at its loaded value, a dropped quadword while the countdown is live, an error clear that coincides with an error set, and bulk data sent to the broadcast row.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

    localparam int WORD_W    = 32;
    localparam int QW_WORDS  = 4;
    localparam int TYPE_W    = 8;
    localparam int ROW_W     = 5;
    localparam int REG_W     = 6;
    localparam int BULK_MULT = 25;

    localparam logic [TYPE_W-1:0] PKT_FRAME = 8'h01;
    localparam logic [TYPE_W-1:0] PKT_CTRL  = 8'h02;
    localparam logic [REG_W-1:0]  REG_BULK  = 6'h02;
    localparam logic [ROW_W-1:0]  ROW_ALL   = 5'h1F;

    typedef logic [WORD_W-1:0]                word_t;
    typedef logic [QW_WORDS-1:0][WORD_W-1:0]  qword_t;

    typedef struct packed {
        logic [TYPE_W-1:0] ptype;
        logic [ROW_W-1:0]  row;
        logic [REG_W-1:0]  regad;
    } hdr_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_BULK,
        ACT_LOAD,
        ACT_FRAME
    } act_e;

    function automatic hdr_t hdr_of(input word_t w);
        hdr_t h;
        h.ptype = w[31:24];
        h.row   = w[20:16];
        h.regad = w[13:8];
        return h;
    endfunction

    function automatic logic bad_bulk_len(input word_t v);
        return (v % word_t'(BULK_MULT)) != '0;
    endfunction

endpackage

// File: rtl/cqr_gather.sv
module cqr_gather
    import cqr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    output logic              done,
    output qword_t            qword
);
    localparam int HELD = QW_WORDS - 1;
    localparam int SLOT_W = $clog2(QW_WORDS);

    logic [SLOT_W-1:0] slot;
    word_t             held [HELD];
    logic              unused_addr;

    assign slot        = wr_addr[2 +: SLOT_W];
    assign unused_addr = ^{wr_addr[ADDR_W-1:2+SLOT_W], wr_addr[1:0]};
    assign done        = wr_en && (slot == SLOT_W'(HELD));

    for (genvar k = 0; k < HELD; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || done) begin
                held[k] <= '0;
            end else if (wr_en && slot == SLOT_W'(k)) begin
                held[k] <= wr_data;
            end
        end
        assign qword[k] = held[k];
    end
    assign qword[HELD] = wr_data;

    AST_GATHER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done |=> (held[0] == '0 && held[1] == '0 && held[2] == '0)); // R2

endmodule

// File: rtl/cqr_fanout.sv
module cqr_fanout
    import cqr_pkg::*;
#(
    parameter int NUM_ROWS = 15
) (
    input  logic [ROW_W-1:0]    row,
    output logic [NUM_ROWS-1:0] mask,
    output logic                bad
);
    logic bcast;

    assign bcast = (row == ROW_ALL);
    assign bad   = !bcast && (row >= ROW_W'(NUM_ROWS));

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        assign mask[i] = bcast || (row == ROW_W'(i));
    end

endmodule

// File: rtl/cqr_decode.sv
module cqr_decode
    import cqr_pkg::*;
#(
    parameter int NUM_ROWS = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  qword_t              qword,
    input  logic                decomp_en,
    output logic                fire,
    output logic [NUM_ROWS-1:0] mask,
    output logic [REG_W-1:0]    pkt_reg,
    output qword_t              pkt_data,
    output logic                set_bad_row,
    output logic                set_bad_len
);
    word_t            bulk_cnt;
    logic [ROW_W-1:0] bulk_row;
    hdr_t             hdr;
    act_e             act;
    logic [ROW_W-1:0] sel_row;
    logic [NUM_ROWS-1:0] row_mask;
    logic             row_bad;

    assign hdr     = hdr_of(qword[0]);
    assign sel_row = (bulk_cnt != '0) ? bulk_row : hdr.row;

    cqr_fanout #(.NUM_ROWS(NUM_ROWS)) u_fanout (
        .row  (sel_row),
        .mask (row_mask),
        .bad  (row_bad)
    );

    always_comb begin
        act = ACT_NONE;
        if (done && !decomp_en) begin
            if (bulk_cnt != '0) begin
                act = ACT_BULK;
            end else if (hdr.ptype == PKT_CTRL && hdr.regad == REG_BULK) begin
                act = ACT_LOAD;
            end else if (hdr.ptype == PKT_FRAME) begin
                act = ACT_FRAME;
            end
        end
    end

    always_comb begin
        fire        = (act == ACT_BULK) || (act == ACT_FRAME);
        mask        = fire ? row_mask : '0;
        set_bad_row = fire && row_bad;
        set_bad_len = (act == ACT_LOAD) && bad_bulk_len(qword[1]);
        if (act == ACT_BULK) begin
            pkt_reg  = REG_BULK;
            pkt_data = qword;
        end else begin
            pkt_reg     = hdr.regad;
            pkt_data[0] = qword[1];
            pkt_data[1] = qword[2];
            pkt_data[2] = qword[3];
            pkt_data[3] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bulk_cnt <= '0;
            bulk_row <= '0;
        end else begin
            case (act)
                ACT_BULK: bulk_cnt <= bulk_cnt - word_t'(1);
                ACT_LOAD: begin
                    bulk_cnt <= qword[1];
                    bulk_row <= hdr.row;
                end
                default: ;
            endcase
        end
    end

    AST_BULK_STEP: assert property (@(posedge clk) disable iff (rst)
        (done && !decomp_en && bulk_cnt != '0) |=> bulk_cnt == $past(bulk_cnt) - word_t'(1)); // R3

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        decomp_en |=> $stable(bulk_cnt)); // R9

endmodule

// File: rtl/cfg_qword_router.sv
module cfg_qword_router
    import cqr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_ROWS = 15
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          decomp_en,
    input  logic                          err_clr,
    output logic [NUM_ROWS-1:0]           row_valid,
    output logic [REG_W-1:0]              pkt_reg,
    output logic [QW_WORDS*WORD_W-1:0]    pkt_data,
    output logic                          err_bulk_len,
    output logic                          err_bad_row
);
    logic                done;
    qword_t              qword;
    logic                fire;
    logic [NUM_ROWS-1:0] mask;
    logic [REG_W-1:0]    d_reg;
    qword_t              d_data;
    logic                set_bad_row;
    logic                set_bad_len;

    cqr_gather #(.ADDR_W(ADDR_W)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (done),
        .qword   (qword)
    );

    cqr_decode #(.NUM_ROWS(NUM_ROWS)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .qword       (qword),
        .decomp_en   (decomp_en),
        .fire        (fire),
        .mask        (mask),
        .pkt_reg     (d_reg),
        .pkt_data    (d_data),
        .set_bad_row (set_bad_row),
        .set_bad_len (set_bad_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            row_valid    <= '0;
            pkt_reg      <= '0;
            pkt_data     <= '0;
            err_bulk_len <= 1'b0;
            err_bad_row  <= 1'b0;
        end else begin
            row_valid <= mask;
            if (fire) begin
                pkt_reg  <= d_reg;
                pkt_data <= d_data;
            end
            if (set_bad_len)  err_bulk_len <= 1'b1;
            else if (err_clr) err_bulk_len <= 1'b0;
            if (set_bad_row)  err_bad_row  <= 1'b1;
            else if (err_clr) err_bad_row  <= 1'b0;
        end
    end

    AST_ROUTE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ($countones(row_valid) <= 1) || (&row_valid)); // R6

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|row_valid) |-> $past(wr_en && wr_addr[3:2] == 2'd3)); // R1

    AST_DECOMP_DROP: assert property (@(posedge clk) disable iff (rst)
        $past(decomp_en) |-> (row_valid == '0)); // R9

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(err_bad_row) && !$past(err_clr)) |-> err_bad_row); // R7

endmodule

// File: tb/cfg_qword_router_bench.sv
module cfg_qword_router_bench;

    localparam int ADDR_W = 12;
    localparam int NROWS  = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              decomp_en = 1'b0;
    logic              err_clr = 1'b0;
    logic [NROWS-1:0]  row_valid;
    logic [5:0]        pkt_reg;
    logic [127:0]      pkt_data;
    logic              err_bulk_len;
    logic              err_bad_row;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;
    bit compare_on = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    cfg_qword_router #(.ADDR_W(ADDR_W), .NUM_ROWS(NROWS)) u_cfg_qword_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .decomp_en(decomp_en), .err_clr(err_clr), .row_valid(row_valid),
        .pkt_reg(pkt_reg), .pkt_data(pkt_data), .err_bulk_len(err_bulk_len),
        .err_bad_row(err_bad_row)
    );

    task automatic chk(input bit ok, input string t, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0]      m_buf [3];
    longint unsigned  m_cnt;
    int               m_row;
    logic [NROWS-1:0] e_valid;
    logic [5:0]       e_reg;
    logic [127:0]     e_data;
    logic             e_len, e_row;

    function automatic void deliver(input int row, input logic [5:0] r, input logic [127:0] d);
        e_reg  = r;
        e_data = d;
        if (row == 31) e_valid = '1;
        else if (row < NROWS) e_valid = NROWS'(1) << row;
        else e_row = 1'b1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            foreach (m_buf[i]) m_buf[i] = '0;
            m_cnt = 0; m_row = 0; e_valid = '0; e_reg = '0; e_data = '0;
            e_len = 0; e_row = 0;
        end else begin
            logic [31:0] w0, w1, w2, w3;
            e_valid = '0;
            if (err_clr) begin e_len = 0; e_row = 0; end
            if (wr_en) begin
                if (wr_addr[3:2] != 2'd3) begin
                    m_buf[wr_addr[3:2]] = wr_data;
                end else begin
                    w0 = m_buf[0]; w1 = m_buf[1]; w2 = m_buf[2]; w3 = wr_data;
                    foreach (m_buf[i]) m_buf[i] = '0;
                    if (!decomp_en) begin
                        if (m_cnt != 0) begin
                            deliver(m_row, 6'h02, {w3, w2, w1, w0});
                            m_cnt--;
                        end else if (w0[31:24] == 8'h02 && w0[13:8] == 6'h02) begin
                            m_cnt = w1;
                            m_row = int'(w0[20:16]);
                            if (w1 % 25 != 0) e_len = 1;
                        end else if (w0[31:24] == 8'h01) begin
                            deliver(int'(w0[20:16]), w0[13:8], {32'h0, w3, w2, w1});
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            chk(row_valid == e_valid, {tag, " row_valid"}, 128'(row_valid), 128'(e_valid));
            if (e_valid != '0) begin
                chk(pkt_reg == e_reg, {tag, " pkt_reg"}, 128'(pkt_reg), 128'(e_reg));
                chk(pkt_data == e_data, {tag, " pkt_data"}, pkt_data, e_data);
            end
            chk(err_bulk_len == e_len, {tag, " err_bulk_len"}, 128'(err_bulk_len), 128'(e_len));
            chk(err_bad_row == e_row, {tag, " err_bad_row"}, 128'(err_bad_row), 128'(e_row));
        end
    end

    always @(posedge clk) begin
        if (cycles > 40000 && !finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<40000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] hdr(input logic [7:0] t, input logic [4:0] row, input logic [5:0] r);
        return {t, 3'b000, row, 2'b00, r, 8'h00};
    endfunction

    task automatic wr(input int slot, input logic [31:0] d, input logic [7:0] hi);
        wr_en   = 1'b1;
        wr_addr = {hi[ADDR_W-5:0], 2'(slot), 2'b01};
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic qw(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
        wr(0, w0, 8'h3A); wr(1, w1, 8'h05); wr(2, w2, 8'hC0); wr(3, w3, 8'h11);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(row_valid == '0 && !err_bulk_len && !err_bad_row, "R11 reset outputs",
            128'({row_valid, err_bulk_len, err_bad_row}), 128'(0));
        rst = 1'b0;
        compare_on = 1;
        @(negedge clk);

        // R5 / R6 / R1: frame packet to row 3
        tag = "R5";
        wr(0, hdr(8'h01, 5'd3, 6'h15), 8'h00);
        wr(1, 32'h1111_0001, 8'h00);
        wr(2, 32'h2222_0002, 8'h00);
        chk(row_valid == '0, "R1 no packet before slot 3", 128'(row_valid), 128'(0));
        wr(3, 32'h3333_0003, 8'h00);
        chk(row_valid == NROWS'(1 << 3), "R6 single row 3", 128'(row_valid), 128'(1 << 3));
        chk(pkt_reg == 6'h15, "R5 reg addr", 128'(pkt_reg), 128'(6'h15));
        chk(pkt_data == {32'h0, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001}, "R5 data lanes",
            pkt_data, {32'h0, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001});
        @(negedge clk);
        chk(row_valid == '0, "R1 one-cycle strobe", 128'(row_valid), 128'(0));

        // R1: slots chosen out of order by address
        tag = "R1";
        wr(2, 32'hCCCC, 8'h7F); wr(0, hdr(8'h01, 5'd14, 6'h01), 8'h02); wr(1, 32'hBBBB, 8'h44);
        wr(3, 32'hDDDD, 8'h99);
        chk(row_valid == NROWS'(1 << 14) && pkt_data[95:0] == {32'hDDDD, 32'hCCCC, 32'hBBBB},
            "R1 slot by address", pkt_data, {32'h0, 32'hDDDD, 32'hCCCC, 32'hBBBB});

        // R2: stale slots cleared
        tag = "R2";
        wr(0, hdr(8'h01, 5'd2, 6'h04), 8'h00);
        wr(3, 32'hEEEE, 8'h00);
        chk(pkt_data == {32'h0, 32'hEEEE, 32'h0, 32'h0}, "R2 cleared slots",
            pkt_data, {32'h0, 32'hEEEE, 32'h0, 32'h0});

        // R6: broadcast
        tag = "R6";
        qw(hdr(8'h01, 5'd31, 6'h09), 32'hA, 32'hB, 32'hC);
        chk(row_valid == '1, "R6 broadcast", 128'(row_valid), 128'({NROWS{1'b1}}));

        // R7: nonexistent row
        tag = "R7";
        qw(hdr(8'h01, 5'd20, 6'h09), 32'h1, 32'h2, 32'h3);
        chk(row_valid == '0 && err_bad_row, "R7 bad row", 128'({row_valid, err_bad_row}), 128'(1));
        repeat (2) @(negedge clk);
        chk(err_bad_row, "R7 sticky", 128'(err_bad_row), 128'(1));
        tag = "R8";
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk(!err_bad_row, "R8 clear", 128'(err_bad_row), 128'(0));

        // R10: ignored headers
        tag = "R10";
        qw(hdr(8'h05, 5'd1, 6'h02), 32'd25, 32'h0, 32'h0);
        chk(row_valid == '0, "R10 unknown type", 128'(row_valid), 128'(0));
        qw(hdr(8'h02, 5'd1, 6'h03), 32'd25, 32'h0, 32'h0);
        qw(hdr(8'h01, 5'd0, 6'h07), 32'h5, 32'h6, 32'h7);
        chk(row_valid == NROWS'(1) && pkt_reg == 6'h07, "R10 ctrl other reg not loaded",
            128'({row_valid, pkt_reg}), 128'({NROWS'(1), 6'h07}));

        // R4 / R3: load 25 to row 5 and drain
        tag = "R4";
        qw(hdr(8'h02, 5'd5, 6'h02), 32'd25, 32'h0, 32'h0);
        chk(row_valid == '0 && !err_bulk_len, "R4 load no packet",
            128'({row_valid, err_bulk_len}), 128'(0));
        tag = "R3";
        for (int i = 0; i < 25; i++) begin
            qw(hdr(8'h01, 5'd9, 6'h3F), 32'h100 + i, 32'h200 + i, 32'h300 + i);
            if (i == 0 || i == 24)
                chk(row_valid == NROWS'(1 << 5) && pkt_reg == 6'h02 &&
                    pkt_data == {32'h300 + i, 32'h200 + i, 32'h100 + i, hdr(8'h01, 5'd9, 6'h3F)},
                    "R3 bulk to latched row", pkt_data,
                    {32'h300 + i, 32'h200 + i, 32'h100 + i, hdr(8'h01, 5'd9, 6'h3F)});
        end
        qw(hdr(8'h01, 5'd9, 6'h3F), 32'h1, 32'h2, 32'h3);
        chk(row_valid == NROWS'(1 << 9) && pkt_reg == 6'h3F, "R3 countdown ended",
            128'({row_valid, pkt_reg}), 128'({NROWS'(1 << 9), 6'h3F}));

        // R9: drop while countdown live
        tag = "R9";
        qw(hdr(8'h02, 5'd6, 6'h02), 32'd25, 32'h0, 32'h0);
        decomp_en = 1'b1;
        qw(32'h1, 32'h2, 32'h3, 32'h4);
        chk(row_valid == '0, "R9 dropped", 128'(row_valid), 128'(0));
        decomp_en = 1'b0;
        for (int i = 0; i < 25; i++) qw(32'h0, 32'h0, 32'h0, 32'(i));
        qw(hdr(8'h01, 5'd1, 6'h0A), 32'h1, 32'h2, 32'h3);
        chk(row_valid == NROWS'(1 << 1) && pkt_reg == 6'h0A, "R9 countdown unchanged",
            128'({row_valid, pkt_reg}), 128'({NROWS'(1 << 1), 6'h0A}));

        // R8: bad length, clear coincident with set; bulk to broadcast row
        tag = "R8";
        wr(0, hdr(8'h02, 5'd31, 6'h02), 8'h00); wr(1, 32'd7, 8'h00); wr(2, 32'h0, 8'h00);
        err_clr = 1'b1;
        wr(3, 32'h0, 8'h00);
        err_clr = 1'b0;
        chk(err_bulk_len, "R8 set wins over clear", 128'(err_bulk_len), 128'(1));
        tag = "R3";
        for (int i = 0; i < 7; i++) begin
            qw(32'h9, 32'h8, 32'h7, 32'(i));
            chk(row_valid == '1 && pkt_reg == 6'h02, "R3 bulk broadcast",
                128'({row_valid, pkt_reg}), 128'({{NROWS{1'b1}}, 6'h02}));
        end
        tag = "R8";
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk(!err_bulk_len, "R8 cleared", 128'(err_bulk_len), 128'(0));

        // R11: mid-stream reset clears partial gather and countdown
        tag = "R11";
        qw(hdr(8'h02, 5'd4, 6'h02), 32'd50, 32'h0, 32'h0);
        wr(1, 32'hFFFF, 8'h00);
        compare_on = 0;
        rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
        compare_on = 1;
        wr(0, hdr(8'h01, 5'd8, 6'h11), 8'h00);
        wr(3, 32'h42, 8'h00);
        chk(row_valid == NROWS'(1 << 8) && pkt_data[31:0] == 32'h0, "R11 reset cleared state",
            128'({row_valid, pkt_data[31:0]}), 128'({NROWS'(1 << 8), 32'h0}));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule